// File: doc/BRIEF.md
# Modem Handshake and Auto-Enable Controller

This block looks after the modem handshake lines of a multi-channel serial controller (two channels by default). Each channel has two active-low handshake inputs. One is a clear-to-send line. The other is a carrier-detect line. Each input is brought into the clock domain through a synchroniser. A transition in either direction is recorded in a sticky change flag, which can raise a per-channel interrupt. When a channel's auto-enable bit is set, the clear-to-send line gates its transmitter and the carrier-detect line gates its receiver. When the bit is clear, the two lines are plain status inputs.

Each channel also drives one active-low output. It has two modes. In ready mode it is a terminal-ready level set by software. In request mode it becomes a transmit service request for an external DMA controller. The request is driven from the channel's transmit-buffer-empty status.

Software reaches the block through a flat register port. Address bit 0 selects the control register (0) or the status register (1) of a channel. The upper address bits pick the channel. Reads are combinational. Writes take effect at the next clock edge.

Top module: `modem_ctl`

## Requirements
- R1: After reset, all transmit and receive enables are 0, every terminal-ready/request output is 1, every interrupt is 0, and both status change flags read 0.
- R2: Control bit 0 is auto-enable and bit 4 is transmit-on. With auto-enable set, tx_en equals transmit-on AND the synchronised clear-to-send being low. tx_en follows a pin change at the second rising edge after the change.
- R3: Control bit 5 is receive-on. With auto-enable set, rx_en equals receive-on AND the synchronised carrier-detect being low, with the same two-edge latency.
- R4: With auto-enable clear, tx_en equals transmit-on and rx_en equals receive-on, whatever the handshake pins do.
- R5: A change of a handshake pin in either direction sets its sticky flag at the third rising edge after the change. Status bit 2 is the clear-to-send flag and status bit 3 is the carrier-detect flag. This happens in both modes.
- R6: Writing 1 to status bit 2 or 3 clears that flag. Writing 0 leaves it unchanged. If a new edge arrives in the same cycle as the clear, the flag stays set.
- R7: Control bit 3 is interrupt-enable. A channel's irq is 1 exactly when interrupt-enable is set and at least one of its change flags is set.
- R8: Control bit 1 is request mode and bit 2 is ready-on. In ready mode (bit 1 = 0), the output pin is the inverse of ready-on.
- R9: In request mode, the output pin is low exactly when that channel's txbuf_empty is 1 and its tx_en is 1. The output reacts combinationally to txbuf_empty.
- R10: Every control bit, flag, enable, output and interrupt of one channel is unaffected by writes to, or pin activity on, the other channel.
- R11: Reading the control address returns the six control bits in bits 5:0. Reading the status address returns the synchronised clear-to-send active (bit 0), carrier-detect active (bit 1) and the two change flags. All unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n | input | NCH | Raw clear-to-send pins, active low |
| dcd_n | input | NCH | Raw carrier-detect pins, active low |
| txbuf_empty | input | NCH | Transmit buffer empty, per channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | {channel, select}; select 0 = control, 1 = status |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| tx_en | output | NCH | Transmitter enable per channel |
| rx_en | output | NCH | Receiver enable per channel |
| dtr_req_n | output | NCH | Active-low terminal-ready level or transmit request |
| irq | output | NCH | Per-channel interrupt request |

## Verification
The bench attacks the clear-versus-edge collision. A design that lets the clear win there loses a pin transition without a trace. It also toggles pins while auto-enable is clear. A design that gates anyway would drop tx_en or rx_en. Rising and falling edges are both driven, so a design that records only one polarity misses half of the changes. The bench switches txbuf_empty in request mode, and repeats every operation on the second channel while comparing the first. This catches a request pin that ignores tx_en, latency off by one edge, and channel cross-talk.

// File: rtl/modem_pkg.sv
package modem_pkg;

  // control register bit positions
  localparam int unsigned CB_AUTO   = 0;
  localparam int unsigned CB_REQ    = 1;
  localparam int unsigned CB_RDY    = 2;
  localparam int unsigned CB_IRQEN  = 3;
  localparam int unsigned CB_TXON   = 4;
  localparam int unsigned CB_RXON   = 5;
  localparam int unsigned CTRL_BITS = 6;

  // status register bit positions
  localparam int unsigned SB_CTS    = 0;
  localparam int unsigned SB_DCD    = 1;
  localparam int unsigned SB_CTSCHG = 2;
  localparam int unsigned SB_DCDCHG = 3;

  typedef struct packed {
    logic rx_on;
    logic tx_on;
    logic irq_en;
    logic rdy_on;
    logic req_mode;
    logic auto_en;
  } chan_ctrl_t;

endpackage

// File: rtl/hs_sync_edge.sv
module hs_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic active,
  output logic toggled
);

  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] sh_q, sh_d;
  logic          prev_q, prev_d;

  // next state: shift toward the last stage, remember the last stage
  always_comb begin
    sh_d   = {sh_q[LAST-1:0], pin_n};
    prev_d = sh_q[LAST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= sh_d;
      prev_q <= prev_d;
    end
  end

  assign active  = ~sh_q[LAST];
  assign toggled = sh_q[LAST] ^ prev_q;

endmodule

// File: rtl/hs_chan.sv
module hs_chan
  import modem_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_stat,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cts_act,
  input  logic              dcd_act,
  input  logic              cts_tog,
  input  logic              dcd_tog,
  input  logic              txbuf_empty,
  output logic              tx_en,
  output logic              rx_en,
  output logic              dtr_req_n,
  output logic              irq,
  output logic [DATA_W-1:0] rd_ctrl,
  output logic [DATA_W-1:0] rd_stat
);

  chan_ctrl_t ctrl_q, ctrl_d;
  logic       cchg_q, cchg_d;
  logic       dchg_q, dchg_d;
  logic       clr_c, clr_d;

  assign clr_c = wr_stat & wdata[SB_CTSCHG];
  assign clr_d = wr_stat & wdata[SB_DCDCHG];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = chan_ctrl_t'(wdata[CTRL_BITS-1:0]);
    // a fresh edge beats a simultaneous clear
    cchg_d = (cchg_q & ~clr_c) | cts_tog;
    dchg_d = (dchg_q & ~clr_d) | dcd_tog;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cchg_q <= 1'b0;
      dchg_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      cchg_q <= cchg_d;
      dchg_q <= dchg_d;
    end
  end

  // enables and pin outputs
  always_comb begin
    tx_en     = ctrl_q.tx_on & (~ctrl_q.auto_en | cts_act);
    rx_en     = ctrl_q.rx_on & (~ctrl_q.auto_en | dcd_act);
    dtr_req_n = ctrl_q.req_mode ? ~(txbuf_empty & tx_en) : ~ctrl_q.rdy_on;
    irq       = ctrl_q.irq_en & (cchg_q | dchg_q);
  end

  always_comb begin
    rd_ctrl                 = '0;
    rd_ctrl[CTRL_BITS-1:0]  = ctrl_q;
    rd_stat                 = '0;
    rd_stat[SB_CTS]         = cts_act;
    rd_stat[SB_DCD]         = dcd_act;
    rd_stat[SB_CTSCHG]      = cchg_q;
    rd_stat[SB_DCDCHG]      = dchg_q;
  end

  AST_TXEN_NEEDS_CTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.auto_en && tx_en) |-> cts_act); // R2
  AST_RXEN_NEEDS_DCD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.auto_en && rx_en) |-> dcd_act); // R3
  AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_tog || dcd_tog) |=> (cchg_q || dchg_q)); // R5
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cchg_q && !clr_c) |=> cchg_q); // R6
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_c && !cts_tog) |=> !cchg_q); // R6

endmodule

// File: rtl/modem_ctl.sv
module modem_ctl
  import modem_pkg::*;
#(
  parameter int unsigned NCH         = 2,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = $clog2(NCH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    cts_n,
  input  logic [NCH-1:0]    dcd_n,
  input  logic [NCH-1:0]    txbuf_empty,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NCH-1:0]    tx_en,
  output logic [NCH-1:0]    rx_en,
  output logic [NCH-1:0]    dtr_req_n,
  output logic [NCH-1:0]    irq
);

  localparam int unsigned CH_W = ADDR_W - 1;

  logic [CH_W-1:0]   sel_ch;
  logic              sel_stat;
  logic [DATA_W-1:0] rd_ctrl [NCH];
  logic [DATA_W-1:0] rd_stat [NCH];

  assign sel_ch   = reg_addr[ADDR_W-1:1];
  assign sel_stat = reg_addr[0];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic cts_act, dcd_act, cts_tog, dcd_tog;
    logic hit;

    assign hit = reg_we && (sel_ch == CH_W'(i));

    hs_sync_edge #(.STAGES(SYNC_STAGES)) u_cts (
      .clk(clk), .rst_n(rst_n), .pin_n(cts_n[i]),
      .active(cts_act), .toggled(cts_tog));

    hs_sync_edge #(.STAGES(SYNC_STAGES)) u_dcd (
      .clk(clk), .rst_n(rst_n), .pin_n(dcd_n[i]),
      .active(dcd_act), .toggled(dcd_tog));

    hs_chan #(.DATA_W(DATA_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_ctrl(hit && !sel_stat), .wr_stat(hit && sel_stat),
      .wdata(reg_wdata),
      .cts_act(cts_act), .dcd_act(dcd_act),
      .cts_tog(cts_tog), .dcd_tog(dcd_tog),
      .txbuf_empty(txbuf_empty[i]),
      .tx_en(tx_en[i]), .rx_en(rx_en[i]),
      .dtr_req_n(dtr_req_n[i]), .irq(irq[i]),
      .rd_ctrl(rd_ctrl[i]), .rd_stat(rd_stat[i]));

    AST_REQ_ONLY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (!dtr_req_n[i] && !rd_ctrl[i][CB_RDY]) |-> (txbuf_empty[i] && tx_en[i])); // R9
  end

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NCH; k++) begin
      if (sel_ch == CH_W'(k)) reg_rdata = sel_stat ? rd_stat[k] : rd_ctrl[k];
    end
  end

endmodule

// File: tb/test_modem_ctl.sv
module test_modem_ctl;

  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] cts_n = '1, dcd_n = '1, txbuf_empty = '0;
  logic           reg_we = 1'b0;
  logic [1:0]     reg_addr = '0;
  logic [7:0]     reg_wdata = '0;
  logic [7:0]     reg_rdata;
  logic [NCH-1:0] tx_en, rx_en, dtr_req_n, irq;

  int n_run = 0, n_fail = 0;
  bit chk_on = 1'b0;

  always #5 clk = ~clk;

  modem_ctl i_modem_ctl (
    .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .dcd_n(dcd_n),
    .txbuf_empty(txbuf_empty), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_en(tx_en),
    .rx_en(rx_en), .dtr_req_n(dtr_req_n), .irq(irq));

  // reference model: pin history (bit0 newest), control word, flags
  bit [2:0] mc [NCH];
  bit [2:0] md [NCH];
  bit [5:0] mctl [NCH];
  bit       mcf [NCH];
  bit       mdf [NCH];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        mc[c] = 3'b111; md[c] = 3'b111; mctl[c] = '0; mcf[c] = 0; mdf[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        bit wr;
        wr = reg_we && (reg_addr[1] == c[0]);
        mcf[c] = (mcf[c] && !(wr && reg_addr[0] && reg_wdata[2])) || (mc[c][1] != mc[c][2]);
        mdf[c] = (mdf[c] && !(wr && reg_addr[0] && reg_wdata[3])) || (md[c][1] != md[c][2]);
        mc[c] = {mc[c][1:0], cts_n[c]};
        md[c] = {md[c][1:0], dcd_n[c]};
        if (wr && !reg_addr[0]) mctl[c] = reg_wdata[5:0];
      end
    end
  end

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit e_tx(int c);
    return mctl[c][4] && (!mctl[c][0] || !mc[c][1]);
  endfunction

  always @(negedge clk) begin
    if (chk_on && rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        bit etx, erx, epin;
        etx  = e_tx(c);
        erx  = mctl[c][5] && (!mctl[c][0] || !md[c][1]);
        epin = mctl[c][1] ? !(txbuf_empty[c] && etx) : !mctl[c][2];
        check(mctl[c][0] ? "R2 R10 tx_en" : "R4 R10 tx_en", tx_en[c], etx);
        check(mctl[c][0] ? "R3 R10 rx_en" : "R4 R10 rx_en", rx_en[c], erx);
        check(mctl[c][1] ? "R9 dtr_req_n" : "R8 dtr_req_n", dtr_req_n[c], epin);
        check("R7 irq", irq[c], mctl[c][3] && (mcf[c] || mdf[c]));
      end
      begin
        int c;
        bit [7:0] er;
        c = reg_addr[1];
        if (reg_addr[0]) er = {4'b0, mdf[c], mcf[c], !md[c][1], !mc[c][1]};
        else er = {2'b0, mctl[c]};
        check("R5 R6 R11 reg_rdata", reg_rdata, er);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(bit [1:0] a, bit [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    tick();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit [15:0] lfsr;
    tick(3);
    // R1: reset state
    check("R1 tx_en", tx_en, 0);
    check("R1 rx_en", rx_en, 0);
    check("R1 dtr_req_n", dtr_req_n, 2'b11);
    check("R1 irq", irq, 0);
    reg_addr = 2'b01; #1;
    check("R1 status", reg_rdata, 0);
    rst_n = 1'b1;
    tick();
    chk_on = 1'b1;

    // R4: auto-enable clear, pins toggle without gating
    wr(2'b00, 8'h30);
    cts_n[0] = 0; dcd_n[0] = 0; tick(4);
    cts_n[0] = 1; tick(4);
    reg_addr = 2'b01; tick(2);
    // R6: write 0 no effect, write 1 clears
    wr(2'b01, 8'h00); tick(2);
    wr(2'b01, 8'h04); tick(2);
    wr(2'b01, 8'h08); tick(2);

    // R2 R3: auto-enable set
    wr(2'b00, 8'h39);
    dcd_n[0] = 1; tick(4);
    cts_n[0] = 0; tick(3);
    dcd_n[0] = 0; tick(4);
    cts_n[0] = 1; tick(4);

    // R6: clear collides with a new edge, flag stays set
    wr(2'b01, 8'h0C);
    cts_n[0] = 0; tick(2);
    wr(2'b01, 8'h04); tick(3);
    wr(2'b01, 8'h0C); tick(2);

    // R8: ready mode level
    wr(2'b00, 8'h04); tick(2);
    wr(2'b00, 8'h00); tick(2);

    // R9: request mode
    wr(2'b00, 8'h13);
    txbuf_empty[0] = 1; tick(2);
    cts_n[0] = 1; tick(4);
    cts_n[0] = 0; tick(4);
    txbuf_empty[0] = 0; tick(2);

    // R10: channel B, channel A left alone and compared
    wr(2'b10, 8'h3B);
    reg_addr = 2'b11;
    cts_n[1] = 0; dcd_n[1] = 0; tick(4);
    txbuf_empty[1] = 1; tick(2);
    wr(2'b10, 8'h1A); tick(3);
    wr(2'b11, 8'h0C); tick(3);

    // mixed activity on both channels
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cts_n = lfsr[1:0]; dcd_n = lfsr[3:2]; txbuf_empty = lfsr[5:4];
      reg_addr = lfsr[7:6];
      if (lfsr[9:8] == 2'b00) wr(lfsr[11:10], lfsr[15:8]);
      else tick();
    end

    chk_on = 1'b0;
    tick();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule